// File: doc/BRIEF.md
# Dual-Mode Framed Serial Command Receiver

This block takes 16-bit command words from a three-wire serial link made up of a serial clock, an active-low frame marker and a data line. It runs on a faster system clock. All three link wires pass through multi-flop synchronisers, and link edges are found in the system clock domain. A falling edge of the frame marker opens a word. Data is then captured most significant bit first on each falling edge of the serial clock. A finished word is handed to a downstream register decoder as a registered word together with a one-cycle valid strobe.

Two framing disciplines are supported, chosen by a mode input that is latched when a word opens. In processor framing, the frame marker must stay low until all sixteen bits are in. The word is handed on only when the marker returns high, and a word whose marker rises early is thrown away. In DSP framing, the marker is only a start pulse. The receiver counts sixteen bits on its own and hands the word on at the sixteenth edge.

A cascade output repeats the captured data stream sixteen serial clock edges late, so that further receivers can be chained on the same link. An enable input gates this output, and when the enable is clear the output stays low.

Top module: `framed_cmd_rx`

## Requirements
- R1: While reset is held and straight after it, `cmd_word_o` is 0, `cmd_valid_o` is 0 and `chain_dat_o` is 0.
- R2: A falling edge of `frame_n_i` opens a word. Bits of `ser_dat_i` are captured on falling edges of `ser_clk_i`. The first captured bit lands in bit 15 of `cmd_word_o` and the sixteenth captured bit lands in bit 0.
- R3: In processor framing (`proc_mode_i` = 1 at word start), a word with sixteen captured bits is handed on only after `frame_n_i` rises. No strobe appears before that rise.
- R4: In processor framing, a rise of `frame_n_i` after fewer than sixteen captured bits discards the word: no strobe is given and `cmd_word_o` keeps its previous value.
- R5: In processor framing, serial clock falling edges after the sixteenth within one word are ignored. The handed-on word holds the first sixteen bits.
- R6: In DSP framing (`proc_mode_i` = 0 at word start), the word is handed on at the sixteenth falling edge whatever the level of `frame_n_i`, and a later rise of `frame_n_i` produces no further strobe.
- R7: A falling edge of `frame_n_i` in the middle of a word restarts the bit count, and the next sixteen bits form the word.
- R8: The framing mode is taken from `proc_mode_i` at the falling edge of `frame_n_i` that opens a word. A change of `proc_mode_i` during the word has no effect on that word.
- R9: `cmd_valid_o` is high for exactly one system clock per handed-on word, and `cmd_word_o` changes only in a cycle where `cmd_valid_o` is high.
- R10: With `chain_en_i` = 1, after each serial clock falling edge `chain_dat_o` shows the data bit captured sixteen falling edges earlier. Bits before the first sixteen edges after reset read as 0.
- R11: With `chain_en_i` = 0, `chain_dat_o` stays 0 whatever the data stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the link, asynchronous |
| frame_n_i | input | 1 | Active-low frame marker, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| proc_mode_i | input | 1 | 1 = processor framing, 0 = DSP framing |
| chain_en_i | input | 1 | Enables the cascade output |
| cmd_word_o | output | 16 | Last handed-on command word |
| cmd_valid_o | output | 1 | One-cycle strobe for a new word |
| chain_dat_o | output | 1 | Data stream delayed by sixteen serial edges |

## Verification
Words are sent in processor framing with an on-time marker rise, an early rise and surplus clock edges. Together these separate commit-on-rise from commit-on-count and show that short words are dropped and surplus bits are ignored. DSP words are sent with a brief start pulse, and separately with the marker held low, to show that the count alone closes the word. A mid-word restart and a mode flip during a word show that the counter reset and the mode latch are in place. The cascade output is compared against a stream history in the bench after every serial edge, with the enable both set and clear.

// File: rtl/framed_rx_pkg.sv
package framed_rx_pkg;

  localparam int unsigned FRX_WORD_W      = 16;
  localparam int unsigned FRX_SYNC_STAGES = 2;

  // Edge events seen in the system clock domain
  typedef struct packed {
    logic sclk_fall;
    logic fs_fall;
    logic fs_rise;
    logic din;
  } rx_evt_t;

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= RST_VAL;
          else     stg_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= RST_VAL;
          else     stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/frx_edge_det.sv
module frx_edge_det
  import framed_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sclk_s,
  input  logic    fs_s,
  input  logic    din_s,
  output rx_evt_t evt_o
);

  logic sclk_prev_q;
  logic fs_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b1;
      fs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      fs_prev_q   <= fs_s;
    end
  end

  always_comb begin
    evt_o.sclk_fall = sclk_prev_q & ~sclk_s;
    evt_o.fs_fall   = fs_prev_q & ~fs_s;
    evt_o.fs_rise   = ~fs_prev_q & fs_s;
    evt_o.din       = din_s;
  end

endmodule

// File: rtl/frx_frame_ctrl.sv
module frx_frame_ctrl
  import framed_rx_pkg::*;
#(
  parameter int unsigned WORD_W = FRX_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  rx_evt_t           evt_i,
  input  logic              proc_mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              active_q;
  logic              mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [WORD_W-1:0] shifted;

  assign shifted = {shreg_q[WORD_W-2:0], evt_i.din};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i.fs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        mode_q   <= proc_mode_i;
      end else if (active_q) begin
        if (mode_q) begin
          if (evt_i.fs_rise) begin
            active_q <= 1'b0;
            if (cnt_q == CNT_FULL) begin
              word_q  <= shreg_q;
              valid_q <= 1'b1;
            end
          end else if (evt_i.sclk_fall && (cnt_q < CNT_FULL)) begin
            shreg_q <= shifted;
            cnt_q   <= cnt_q + 1'b1;
          end
        end else if (evt_i.sclk_fall) begin
          shreg_q <= shifted;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            word_q   <= shifted;
            valid_q  <= 1'b1;
            active_q <= 1'b0;
          end
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R5: the bit counter never passes a full word
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);

  // R9: strobe lasts a single cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R9: word output moves only together with the strobe
  a_r9_word_with_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> valid_q);

  // R3, R4: processor framing hands on only complete words
  a_r3_proc_full_word: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(mode_q)) |-> ($past(cnt_q) == CNT_FULL));

  // R6: DSP framing hands on at the last bit edge
  a_r6_dsp_on_count: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !$past(mode_q)) |-> ($past(cnt_q) == CNT_LAST && $past(evt_i.sclk_fall)));

endmodule

// File: rtl/frx_chain_delay.sv
module frx_chain_delay #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_i,
  input  logic din_i,
  input  logic chain_en_i,
  output logic chain_o
);

  logic [DEPTH-1:0] dly_q;
  logic             tap_q;
  logic             out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      tap_q <= 1'b0;
    end else if (shift_i) begin
      dly_q <= {dly_q[DEPTH-2:0], din_i};
      tap_q <= dly_q[DEPTH-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= chain_en_i & tap_q;
  end

  assign chain_o = out_q;

  // R11: a cleared enable keeps the cascade output low
  a_r11_chain_off: assert property (@(posedge clk) disable iff (rst)
    !$past(chain_en_i) |-> !out_q);

endmodule

// File: rtl/framed_cmd_rx.sv
module framed_cmd_rx
  import framed_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = FRX_WORD_W,
  parameter int unsigned SYNC_STAGES = FRX_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              frame_n_i,
  input  logic              ser_dat_i,
  input  logic              proc_mode_i,
  input  logic              chain_en_i,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  output logic              chain_dat_o
);

  logic [2:0] link_s;
  rx_evt_t    evt;

  frx_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_clk_i, frame_n_i, ser_dat_i}),
    .sync_o  (link_s)
  );

  frx_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (link_s[2]),
    .fs_s   (link_s[1]),
    .din_s  (link_s[0]),
    .evt_o  (evt)
  );

  frx_frame_ctrl #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt),
    .proc_mode_i (proc_mode_i),
    .word_o      (cmd_word_o),
    .valid_o     (cmd_valid_o)
  );

  frx_chain_delay #(
    .DEPTH (WORD_W)
  ) u_chain (
    .clk        (clk),
    .rst        (rst),
    .shift_i    (evt.sclk_fall),
    .din_i      (evt.din),
    .chain_en_i (chain_en_i),
    .chain_o    (chain_dat_o)
  );

endmodule

// File: tb/test_framed_cmd_rx.sv
module test_framed_cmd_rx;

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk, fs, din, mode, cen;
  logic [15:0] word;
  logic        valid, chain;

  int checks = 0;
  int fails  = 0;
  int vcnt   = 0;
  logic [15:0] vword = '0;
  logic hist [1024];
  int   nfall = 0;
  bit   chain_chk = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  framed_cmd_rx i_framed_cmd_rx (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .frame_n_i(fs), .ser_dat_i(din),
    .proc_mode_i(mode), .chain_en_i(cen), .cmd_word_o(word),
    .cmd_valid_o(valid), .chain_dat_o(chain)
  );

  always @(negedge clk) if (!rst && valid) begin
    vcnt++;
    vword = word;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_bit(logic b);
    logic exp;
    sclk = 1'b1; din = b;
    wait_n(5);
    sclk = 1'b0;
    hist[nfall] = b;
    nfall++;
    wait_n(5);
    if (chain_chk) begin
      exp = (nfall >= 17) ? hist[nfall-17] : 1'b0;
      chk(cen ? "R10 chain delay" : "R11 chain off", chain, cen ? exp : 1'b0);
    end
  endtask

  // bits of pat sent MSB first; fs returns high before bit fs_hi_after
  task automatic run_frame(logic [31:0] pat, int nbits, int fs_hi_after);
    fs = 1'b0;
    wait_n(5);
    for (int i = 0; i < nbits; i++) begin
      if (i == fs_hi_after) begin fs = 1'b1; wait_n(3); end
      sclk_bit(pat[nbits-1-i]);
    end
  endtask

  task automatic fs_up();
    fs = 1'b1;
    wait_n(8);
  endtask

  task automatic t_reset();
    chk("R1 word", word, 0);
    chk("R1 valid", valid, 0);
    chk("R1 chain", chain, 0);
  endtask

  task automatic t_proc_word(logic [15:0] w);
    int c0 = vcnt;
    mode = 1'b1;
    run_frame(w, 16, -1);
    chk("R3 no strobe before rise", vcnt, c0);
    fs_up();
    chk("R3 one strobe after rise", vcnt, c0 + 1);
    chk("R2 word order", vword, w);
    chk("R9 word held", word, w);
  endtask

  task automatic t_proc_cancel();
    int c0 = vcnt;
    logic [15:0] prev = word;
    mode = 1'b1;
    run_frame(16'h3C5A, 10, -1);
    fs_up();
    chk("R4 no strobe", vcnt, c0);
    chk("R4 word kept", word, prev);
  endtask

  task automatic t_proc_extra();
    int c0 = vcnt;
    logic [17:0] p = 18'h2B7E1;
    mode = 1'b1;
    run_frame(p, 18, -1);
    fs_up();
    chk("R5 one strobe", vcnt, c0 + 1);
    chk("R5 first sixteen", vword, p[17:2]);
  endtask

  task automatic t_dsp_pulse(logic [15:0] w);
    int c0 = vcnt;
    mode = 1'b0;
    run_frame(w, 16, 1);
    chk("R6 strobe at count", vcnt, c0 + 1);
    chk("R6 word", vword, w);
  endtask

  task automatic t_dsp_low(logic [15:0] w);
    int c0 = vcnt;
    mode = 1'b0;
    run_frame(w, 16, -1);
    chk("R6 strobe with marker low", vcnt, c0 + 1);
    chk("R6 word", vword, w);
    fs_up();
    chk("R6 rise adds nothing", vcnt, c0 + 1);
  endtask

  task automatic t_restart(logic [15:0] w);
    int c0 = vcnt;
    mode = 1'b0;
    run_frame(32'h15, 5, 2);
    run_frame(w, 16, 1);
    chk("R7 single strobe", vcnt, c0 + 1);
    chk("R7 fresh word", vword, w);
  endtask

  task automatic t_mode_latch(logic [15:0] w);
    int c0 = vcnt;
    mode = 1'b0;
    fs = 1'b0;
    wait_n(5);
    for (int i = 0; i < 16; i++) begin
      if (i == 4) begin mode = 1'b1; fs = 1'b1; wait_n(3); end
      sclk_bit(w[15-i]);
    end
    chk("R8 latched DSP framing", vcnt, c0 + 1);
    chk("R8 word", vword, w);
    mode = 1'b0;
  endtask

  task automatic t_chain();
    cen = 1'b1;
    wait_n(3);
    chain_chk = 1;
    t_dsp_pulse(16'hF00D);
    t_dsp_pulse(16'h6A91);
    t_dsp_pulse(16'h0FF3);
    cen = 1'b0;
    wait_n(3);
    t_dsp_pulse(16'hFFFF);
    t_dsp_pulse(16'hFFFF);
    chain_chk = 0;
  endtask

  initial begin
    rst = 1'b1; sclk = 1'b1; fs = 1'b1; din = 1'b0; mode = 1'b0; cen = 1'b0;
    wait_n(6);
    t_reset();
    rst = 1'b0;
    wait_n(6);
    t_reset();
    t_proc_word(16'hA5C3);
    t_proc_word(16'h8001);
    t_proc_cancel();
    t_proc_extra();
    t_dsp_pulse(16'h1234);
    t_dsp_low(16'hFEDC);
    t_restart(16'h7E81);
    t_mode_latch(16'hC0DE);
    t_chain();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule